// File: doc/BRIEF.md
# Timestamp Compare Toggle Output Generator

This block watches a free-running 32-bit timestamp supplied by a reference-clocked counter and drives one compare pin from it. Software programs a match value, a span (phase length in reference clock cycles), a control word and a signed trim through a small register write port. When the timestamp equals the match value while the block is armed and the span is non-zero, the pin goes to its active level for exactly the span.

With toggle mode off, that single pulse is the whole response: a one-cycle event strobe accompanies it and the block disarms. With toggle mode on, the pin keeps alternating after the first pulse, each active and each inactive phase lasting the span, and no event strobe is issued. A signed 8-bit trim stretches or shrinks exactly one phase and then clears itself, so software can slide the phase of the running square wave by single cycles. A polarity bit picks whether active means high or low.

Top module: `ts_cmp_toggle`

## Requirements
- R1: When armed, with a non-zero span, and `ts_in` equals the match value at a clock edge, `cmp_out` is at its active level from the next cycle for exactly span cycles (no trim pending).
- R2: With toggle mode off, a match gives one pulse only, then the pin returns to inactive and the block is disarmed (the timestamp passing the match value again does nothing); `evt_out` is high for exactly one cycle, the first active cycle.
- R3: With toggle mode on, after the first active phase the pin alternates between inactive and active, every phase lasting span cycles, until disarmed.
- R4: While toggle mode is on, `evt_out` stays low.
- R5: A non-zero trim is an 8-bit two's-complement value added to the length of the next phase that starts after it is written (0x01 lengthens by one cycle, 0xFF shortens by one); the resulting length is clamped to at least 1 cycle (0x80 with span 4 gives 1).
- R6: A trim affects one phase only; the trim register reads back 0 from the cycle that nudged phase begins.
- R7: Control bit 1 is polarity: 1 makes the active level high, 0 makes it low; the pin shows the opposite level whenever it is not active.
- R8: Writing 0 to the span or to the match register disarms the block and drives the pin inactive from the next cycle.
- R9: The block arms only on a write of a non-zero match value; after reset no timestamp value produces activity.
- R10: A synchronous active-high reset clears all registers (toggle off, polarity 0, trim 0), disarms, holds `evt_out` low and leaves the pin at the inactive level (high).
- R11: Register map on `wr_addr`: 0 control (bit 0 toggle enable, bit 1 polarity), 1 match value, 2 span, 3 trim in bits 7:0; `trim_rd` returns the trim register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | TS_W (32) | Write data |
| ts_in | input | TS_W (32) | Current timestamp value |
| cmp_out | output | 1 | Compare / toggle pin |
| evt_out | output | 1 | One-cycle event strobe on a one-shot match |
| trim_rd | output | NUDGE_W (8) | Readback of the trim register |

## Verification
The bench aims at the trim edges: a positive trim pending before the first match (a design that skipped the first phase would give 4 instead of 5), a trim written inside a phase already under way (a design applying it at once would cut that phase short), and the most negative trim, where a missing clamp would underflow the phase counter into a phase billions of cycles long. It also checks that a one-shot does not refire when the timestamp revisits the match value, that the event strobe never appears in toggle mode, and that a zero span or zero match write drops the pin on the very next cycle rather than at the end of the current phase.

// File: rtl/ts_cmp_pkg.sv
package ts_cmp_pkg;

    localparam int REG_ADDR_W   = 2;
    localparam int CTRL_TOG_BIT = 0;
    localparam int CTRL_POL_BIT = 1;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_MATCH = 2'd1,
        SEL_SPAN  = 2'd2,
        SEL_TRIM  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic polarity;
        logic toggle;
    } ctrl_t;

    typedef struct packed {
        logic armed;
        logic running;
        logic active;
    } seq_state_t;

    function automatic ctrl_t decode_ctrl(input logic [1:0] bits);
        ctrl_t c;
        c.toggle   = bits[CTRL_TOG_BIT];
        c.polarity = bits[CTRL_POL_BIT];
        return c;
    endfunction

    function automatic logic pin_level(input logic active, input logic polarity);
        return polarity ? active : ~active;
    endfunction

endpackage

// File: rtl/ts_cmp_regs.sv
module ts_cmp_regs import ts_cmp_pkg::*; #(
    parameter int TS_W    = 32,
    parameter int NUDGE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [TS_W-1:0]       wr_data,
    input  logic                  trim_taken,
    output ctrl_t                 ctrl,
    output logic [TS_W-1:0]       match_val,
    output logic [TS_W-1:0]       span_val,
    output logic [NUDGE_W-1:0]    trim_val,
    output logic                  arm_req,
    output logic                  disarm_req
);

    reg_sel_e sel;
    logic     wr_ctrl, wr_match, wr_span, wr_trim, data_zero;

    always_comb begin
        sel        = reg_sel_e'(wr_addr);
        wr_ctrl    = wr_en && (sel == SEL_CTRL);
        wr_match   = wr_en && (sel == SEL_MATCH);
        wr_span    = wr_en && (sel == SEL_SPAN);
        wr_trim    = wr_en && (sel == SEL_TRIM);
        data_zero  = (wr_data == '0);
        arm_req    = wr_match && !data_zero;
        disarm_req = (wr_match || wr_span) && data_zero;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            match_val <= '0;
            span_val  <= '0;
            trim_val  <= '0;
        end else begin
            if (wr_ctrl)  ctrl      <= decode_ctrl(wr_data[1:0]);
            if (wr_match) match_val <= wr_data;
            if (wr_span)  span_val  <= wr_data;
            if (wr_trim)           trim_val <= wr_data[NUDGE_W-1:0];
            else if (trim_taken)   trim_val <= '0;
        end
    end

    AST_TRIM_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (trim_taken && !wr_trim) |=> (trim_val == '0)); // R6

endmodule

// File: rtl/ts_cmp_match.sv
module ts_cmp_match #(
    parameter int TS_W = 32
) (
    input  logic [TS_W-1:0] ts_in,
    input  logic [TS_W-1:0] match_val,
    input  logic [TS_W-1:0] span_val,
    input  logic            armed,
    input  logic            running,
    output logic            hit
);

    logic ts_equal, span_nz;

    always_comb begin
        ts_equal = (ts_in == match_val);
        span_nz  = |span_val;
        hit      = armed && !running && ts_equal && span_nz;
    end

endmodule

// File: rtl/ts_cmp_seq.sv
module ts_cmp_seq import ts_cmp_pkg::*; #(
    parameter int TS_W    = 32,
    parameter int NUDGE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hit,
    input  logic               arm_req,
    input  logic               disarm_req,
    input  logic               toggle,
    input  logic [TS_W-1:0]    span_val,
    input  logic [NUDGE_W-1:0] trim_val,
    output seq_state_t         st,
    output logic               evt,
    output logic               trim_taken
);

    localparam int CNT_W = TS_W + 1;
    localparam int SUM_W = TS_W + 2;
    localparam logic signed [SUM_W-1:0] MIN_LEN = SUM_W'(1);

    logic [CNT_W-1:0]        left;
    logic [CNT_W-1:0]        phase_len;
    logic signed [SUM_W-1:0] trim_sum;
    logic                    trim_nz, phase_end, phase_start;

    always_comb begin
        trim_nz  = |trim_val;
        trim_sum = $signed({2'b00, span_val})
                 + $signed({{(SUM_W-NUDGE_W){trim_val[NUDGE_W-1]}}, trim_val});
        if (!trim_nz)
            phase_len = {1'b0, span_val};
        else if (trim_sum < MIN_LEN)
            phase_len = CNT_W'(1);
        else
            phase_len = trim_sum[CNT_W-1:0];
        phase_end   = st.running && (left == '0);
        phase_start = hit || (phase_end && toggle);
        trim_taken  = phase_start && trim_nz;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            left <= '0;
            evt  <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (hit) begin
                st.running <= 1'b1;
                st.active  <= 1'b1;
                st.armed   <= 1'b0;
                left       <= phase_len - CNT_W'(1);
                evt        <= !toggle;
            end else if (st.running) begin
                if (left == '0) begin
                    if (toggle) begin
                        st.active <= !st.active;
                        left      <= phase_len - CNT_W'(1);
                    end else begin
                        st.running <= 1'b0;
                        st.active  <= 1'b0;
                    end
                end else begin
                    left <= left - CNT_W'(1);
                end
            end
            if (arm_req) st.armed <= 1'b1;
            if (disarm_req) begin
                st.armed   <= 1'b0;
                st.running <= 1'b0;
                st.active  <= 1'b0;
            end
        end
    end

    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(st.running) |-> st.active); // R1

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt); // R2

    AST_ONESHOT_END: assert property (@(posedge clk) disable iff (rst)
        ($fell(st.running) && !$past(disarm_req)) |-> !$past(toggle)); // R2

    AST_NO_EVT_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (toggle && $past(toggle)) |-> !evt); // R4

    AST_DISARM_ZERO: assert property (@(posedge clk) disable iff (rst)
        disarm_req |=> (!st.running && !st.armed)); // R8

endmodule

// File: rtl/ts_cmp_toggle.sv
module ts_cmp_toggle import ts_cmp_pkg::*; #(
    parameter int TS_W    = 32,
    parameter int NUDGE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [TS_W-1:0]       wr_data,
    input  logic [TS_W-1:0]       ts_in,
    output logic                  cmp_out,
    output logic                  evt_out,
    output logic [NUDGE_W-1:0]    trim_rd
);

    ctrl_t              ctrl;
    logic [TS_W-1:0]    match_val, span_val;
    logic [NUDGE_W-1:0] trim_val;
    logic               arm_req, disarm_req, trim_taken, hit;
    seq_state_t         st;

    ts_cmp_regs #(.TS_W(TS_W), .NUDGE_W(NUDGE_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trim_taken(trim_taken), .ctrl(ctrl),
        .match_val(match_val), .span_val(span_val), .trim_val(trim_val),
        .arm_req(arm_req), .disarm_req(disarm_req)
    );

    ts_cmp_match #(.TS_W(TS_W)) u_match (
        .ts_in(ts_in), .match_val(match_val), .span_val(span_val),
        .armed(st.armed), .running(st.running), .hit(hit)
    );

    ts_cmp_seq #(.TS_W(TS_W), .NUDGE_W(NUDGE_W)) u_seq (
        .clk(clk), .rst(rst), .hit(hit), .arm_req(arm_req),
        .disarm_req(disarm_req), .toggle(ctrl.toggle), .span_val(span_val),
        .trim_val(trim_val), .st(st), .evt(evt_out), .trim_taken(trim_taken)
    );

    assign cmp_out = pin_level(st.active, ctrl.polarity);
    assign trim_rd = trim_val;

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !st.running |-> (cmp_out == !ctrl.polarity)); // R7

endmodule

// File: tb/sim_ts_cmp_toggle.sv
module sim_ts_cmp_toggle;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] tick = 32'd0;
    logic [31:0] ts_off = 32'd0;
    logic [31:0] ts;
    logic        cmp_out, evt_out;
    logic [7:0]  trim_rd;

    assign ts = tick + ts_off;

    ts_cmp_toggle u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ts_in(ts), .cmp_out(cmp_out),
        .evt_out(evt_out), .trim_rd(trim_rd)
    );

    always #10 clk = ~clk;
    always @(posedge clk) tick <= tick + 32'd1;

    int    checks = 0;
    int    fails  = 0;
    int    evt_cnt = 0;
    string tag = "R10";

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    bit     m_tog, m_pol, m_armed, m_run, m_act, m_evt;
    longint m_len, m_cmp, m_left;
    byte    m_trim;

    always @(posedge clk) begin : model
        bit     used;
        longint pl;
        used = 0;
        if (rst) begin
            m_tog = 0; m_pol = 0; m_armed = 0; m_run = 0; m_act = 0; m_evt = 0;
            m_len = 0; m_cmp = 0; m_left = 0; m_trim = 0;
        end else begin
            pl = m_len;
            if (m_trim != 0) begin
                pl = m_len + longint'(m_trim);
                if (pl < 1) pl = 1;
            end
            m_evt = 0;
            if (!m_run) begin
                if (m_armed && longint'(ts) == m_cmp && m_len != 0) begin
                    m_run = 1; m_act = 1; m_armed = 0; m_left = pl - 1;
                    m_evt = !m_tog; used = (m_trim != 0);
                end
            end else if (m_left == 0) begin
                if (m_tog) begin
                    m_act = !m_act; m_left = pl - 1; used = (m_trim != 0);
                end else begin
                    m_run = 0; m_act = 0;
                end
            end else begin
                m_left = m_left - 1;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_tog = wr_data[0]; m_pol = wr_data[1]; end
                    2'd1: begin
                        m_cmp = longint'(wr_data);
                        if (wr_data != 0) m_armed = 1;
                        else begin m_armed = 0; m_run = 0; m_act = 0; end
                    end
                    2'd2: begin
                        m_len = longint'(wr_data);
                        if (wr_data == 0) begin m_armed = 0; m_run = 0; m_act = 0; end
                    end
                    default: m_trim = byte'(wr_data[7:0]);
                endcase
            end
            if (used && !(wr_en && wr_addr == 2'd3)) m_trim = 0;
        end
    end

    always @(negedge clk) begin
        chk(tag, cmp_out, m_pol ? m_act : !m_act, "pin vs model");
        chk(tag, evt_out, m_evt, "event vs model");
        chk(tag, trim_rd, longint'(byte'(m_trim)) & 255, "trim readback vs model");
        if (evt_out) evt_cnt++;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ts(input logic [31:0] v);
        ts_off = v - tick;
    endtask

    task automatic wait_level(input logic lvl);
        for (int i = 0; i < 200 && cmp_out != lvl; i++) @(negedge clk);
    endtask

    task automatic run_len(output int n);
        logic lvl;
        lvl = cmp_out;
        n = 1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (cmp_out != lvl) break;
            n++;
        end
    endtask

    task automatic count_level(input int cycles, input logic lvl, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (cmp_out == lvl) n++;
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        int n;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", cmp_out, 1, "reset pin level");
        chk("R10", evt_out, 0, "reset event");
        chk("R10", trim_rd, 0, "reset trim");
        rst = 1'b0;
        @(negedge clk);

        // R9: no arming without a match write
        tag = "R9";
        set_ts(32'hFFFF_FFF0);
        wr(2'd2, 32'd3);
        count_level(40, 1'b0, n);
        chk("R9", n, 0, "active cycles without arming");

        // R1, R2: one-shot, active high
        tag = "R2";
        wr(2'd0, 32'h2);
        set_ts(32'd100);
        wr(2'd2, 32'd5);
        wr(2'd1, 32'd110);
        evt_cnt = 0;
        wait_level(1'b1);
        run_len(n);
        chk("R1", n, 5, "one-shot pulse width");
        chk("R2", evt_cnt, 1, "event strobes per one-shot");
        set_ts(32'd105);
        count_level(20, 1'b1, n);
        chk("R2", n, 0, "refire after one-shot");

        // R3, R4, R5, R6, R11: toggle mode with trims
        tag = "R5";
        wr(2'd0, 32'h3);
        wr(2'd2, 32'd4);
        wr(2'd3, 32'h01);
        chk("R11", trim_rd, 1, "trim readback");
        set_ts(32'd200);
        wr(2'd1, 32'd210);
        evt_cnt = 0;
        wait_level(1'b1);
        run_len(n);
        chk("R5", n, 5, "first phase with +1 trim");
        chk("R6", trim_rd, 0, "trim cleared after use");
        run_len(n);
        chk("R6", n, 4, "phase after trimmed one");
        wr(2'd3, 32'hFF);
        run_len(n);
        chk("R5", n + 1, 4, "phase already started keeps span");
        run_len(n);
        chk("R5", n, 3, "phase with -1 trim");
        run_len(n);
        chk("R3", n, 4, "toggle phase length");
        wr(2'd3, 32'h80);
        run_len(n);
        chk("R3", n + 1, 4, "toggle phase length before clamp");
        run_len(n);
        chk("R5", n, 1, "clamped phase length");
        run_len(n);
        chk("R3", n, 4, "phase after clamp");
        chk("R4", evt_cnt, 0, "event strobes in toggle mode");

        // R8: disarm by zero span and zero match
        tag = "R8";
        wr(2'd2, 32'd0);
        chk("R8", cmp_out, 0, "pin after zero span write");
        count_level(10, 1'b1, n);
        chk("R8", n, 0, "active cycles after zero span");
        set_ts(32'd300);
        wr(2'd2, 32'd4);
        wr(2'd1, 32'd305);
        wr(2'd1, 32'd0);
        count_level(20, 1'b1, n);
        chk("R8", n, 0, "active cycles after zero match");

        // R7: active-low one-shot
        tag = "R7";
        wr(2'd0, 32'h0);
        chk("R7", cmp_out, 1, "idle level with polarity 0");
        set_ts(32'd400);
        wr(2'd2, 32'd3);
        wr(2'd1, 32'd406);
        wait_level(1'b0);
        run_len(n);
        chk("R7", n, 3, "active-low pulse width");
        chk("R7", cmp_out, 1, "level after active-low pulse");
        repeat (4) @(negedge clk);

        finish_run();
    end

endmodule